// File: doc/BRIEF.md
# Dual-Clock FIFO with Domain-Local Status Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock and leave on the read clock. Each side owns its status outputs. The write side drives a space-available flag and an active-low almost-full flag. The read side drives a data-available flag and an active-low almost-empty flag. Pointers cross between the domains in Gray code through two-stage synchronizers, so each flag is a function of registers clocked by its own port clock.

The output timing mode is fixed by a parameter. In look-ahead mode, the head word moves into the output register without a request, and the data-available flag means "output register holds a fresh word". In this mode a read request consumes that word. In request mode, the data-available flag means "memory holds a word", and each read request copies the next word into the output register. The almost flags compare the memory fill level with two thresholds, X for almost-empty and Y for almost-full. A word that already sits in the output register is not counted in that level. Both thresholds take parameter defaults at reset and can be rewritten from a small register port on the write side.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While reset is asserted and right after it, `in_ready`=1, `almost_full_n`=1, `rd_avail`=0, `almost_empty_n`=0 and `rd_data`=0.
- R2: In look-ahead mode (`LOOKAHEAD`=1), a word written into an empty FIFO at a write-clock edge moves into `rd_data`, and `rd_avail` rises, at the third rising `rd_clk` edge after that write edge. Neither changes at the first or second edge.
- R3: In request mode (`LOOKAHEAD`=0), `rd_avail` rises at the second rising `rd_clk` edge after a write into an empty FIFO. A read request sampled with `rd_avail`=1 loads the head word into `rd_data` at that edge.
- R4: A read request while no word can be delivered leaves `rd_data` unchanged. A write request while `in_ready`=0 is dropped, so the FIFO later yields only the words accepted before it.
- R5: When the FIFO is full and a read frees a location, `in_ready` rises at the second rising `wr_clk` edge after the read edge.
- R6: `almost_empty_n` is 0 when memory holds X words or fewer, and 1 when it holds X+1 or more. After a write, it changes no earlier than the second rising `rd_clk` edge.
- R7: `almost_full_n` is 0 when memory holds DEPTH−Y words or more, and 1 when it holds DEPTH−Y−1 or fewer. After a read, it changes no earlier than the second rising `wr_clk` edge. `in_ready` is 0 exactly when memory holds DEPTH words.
- R8: A word held in the output register in look-ahead mode is not part of the memory level. A look-ahead FIFO therefore accepts DEPTH+1 words, and its almost flags trip one accepted word later than in request mode.
- R9: X and Y reset to `AE_DEFAULT` and `AF_DEFAULT`. A write-clock edge with `cfg_we`=1 loads `cfg_wdata` into X when `cfg_sel`=0, and into Y when `cfg_sel`=1.
- R10: Words leave in the order they were accepted, including when the pointers wrap past the end of the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low, asynchronous assert |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| in_ready | output | 1 | 1 when a memory location is free |
| almost_full_n | output | 1 | 0 when fill level is at least DEPTH−Y |
| cfg_we | input | 1 | Threshold register write strobe |
| cfg_sel | input | 1 | 0 selects X (almost-empty), 1 selects Y (almost-full) |
| cfg_wdata | input | $clog2(DEPTH)+1 | Threshold value |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset, active low, asynchronous assert |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output register |
| rd_avail | output | 1 | Output ready (look-ahead) or not empty (request mode) |
| almost_empty_n | output | 1 | 0 when fill level is X or less |

## Verification
Results fall due at fixed counts of edges after a stimulus. A write updates the write-side flags right after its own edge, the read-side flags two read edges later, and the look-ahead output register three read edges later. A read frees space that the write side sees two write edges later. The latency checks count those edges one by one and sample 1 ns after each. The fill and drain sweeps first wait four read edges and three write edges, so that every flag has settled, and then compare against levels computed from the count of accepted words. Both timing modes run side by side on the same write traffic.

// File: rtl/dcff_pkg.sv
package dcff_pkg;
  // threshold register selector on the configuration port
  typedef enum logic {
    THR_AE = 1'b0,
    THR_AF = 1'b1
  } thr_sel_e;

  // flip-flop stages on every clock-domain crossing
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dcff_sync.sv
module dcff_sync #(
  parameter int unsigned W       = 5,
  parameter int unsigned STAGES  = dcff_pkg::SYNC_STAGES,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dcff_ram.sv
module dcff_ram #(
  parameter int unsigned AW = 4,
  parameter int unsigned W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcff_wr_ctrl.sv
module dcff_wr_ctrl #(
  parameter int unsigned AW         = 4,
  parameter int unsigned AE_DEFAULT = 2,
  parameter int unsigned AF_DEFAULT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW:0]   cfg_wdata,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wr_fire,
  output logic          in_ready,
  output logic          almost_full_n,
  output logic [AW:0]   x_thr
);
  import dcff_pkg::*;

  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] x_q, x_d, y_q, y_d;
  logic [PW-1:0] rbin_s, level;

  always_comb begin
    rbin_s        = gray_to_bin(rgray_s);
    level         = wbin_q - rbin_s;
    in_ready      = (level != DEPTH_V);
    almost_full_n = (level < (DEPTH_V - y_q));
    wr_fire       = wr_en && in_ready;
    wbin_d        = wbin_q + PW'(wr_fire);
    wgray_d       = wbin_d ^ (wbin_d >> 1);
    x_d           = x_q;
    y_d           = y_q;
    if (cfg_we) begin
      if (thr_sel_e'(cfg_sel) == THR_AF) y_d = cfg_wdata;
      else                               x_d = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      x_q     <= PW'(AE_DEFAULT);
      y_q     <= PW'(AF_DEFAULT);
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      x_q     <= x_d;
      y_q     <= y_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
  assign x_thr = x_q;

  // R4: a refused write leaves the write pointer where it was
  p_full_write_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_ready) |=> (wbin_q == $past(wbin_q)));
  // R7: the synchronized level never exceeds the memory size
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_V);
  // R7: a full memory always reports almost-full
  p_full_is_almost_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !almost_full_n);
endmodule

// File: rtl/dcff_rd_ctrl.sv
module dcff_rd_ctrl #(
  parameter int unsigned AW        = 4,
  parameter int unsigned W         = 16,
  parameter bit          LOOKAHEAD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW:0]   x_thr_s,
  input  logic [W-1:0]  mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  rd_data,
  output logic          rd_avail,
  output logic          almost_empty_n
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wbin_s, mlevel;
  logic [W-1:0]  dout_q, dout_d;
  logic          mem_ne, load;

  always_comb begin
    wbin_s         = gray_to_bin(wgray_s);
    mlevel         = wbin_s - rbin_q;
    mem_ne         = (mlevel != '0);
    almost_empty_n = (mlevel > x_thr_s);
  end

  if (LOOKAHEAD) begin : g_lookahead
    logic ov_q, ov_d;

    always_comb begin
      load = mem_ne && (!ov_q || rd_en);
      ov_d = ov_q;
      if (load)       ov_d = 1'b1;
      else if (rd_en) ov_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ov_q <= 1'b0;
      else        ov_q <= ov_d;
    end

    assign rd_avail = ov_q;

    // R2: the output register fills only from a non-empty memory
    p_fill_from_memory_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_q) |-> $past(mem_ne));
  end else begin : g_request
    always_comb load = rd_en && mem_ne;
    assign rd_avail = mem_ne;
  end

  always_comb begin
    rbin_d  = rbin_q + PW'(load);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    dout_d  = load ? mem_q : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      dout_q  <= dout_d;
    end
  end

  assign raddr   = rbin_q[AW-1:0];
  assign rgray   = rgray_q;
  assign rd_data = dout_q;

  // R4: a request against an empty memory keeps the output register
  p_empty_read_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mem_ne) |=> $stable(dout_q));
  // R6: almost-empty released implies memory holds data
  p_ae_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    almost_empty_n |-> mem_ne);
  // R10: read-side level stays within the memory size
  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mlevel <= DEPTH_V);
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DEPTH      = 16,
  parameter bit          LOOKAHEAD  = 1'b1,
  parameter int unsigned AE_DEFAULT = 2,
  parameter int unsigned AF_DEFAULT = 3,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned TW        = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              in_ready,
  output logic              almost_full_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [TW-1:0]     cfg_wdata,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_avail,
  output logic              almost_empty_n
);
  logic [AW-1:0]     waddr, raddr;
  logic [TW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [TW-1:0]     x_thr, x_thr_s;
  logic              wr_fire;
  logic [DATA_W-1:0] mem_q;

  dcff_wr_ctrl #(.AW(AW), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .waddr(waddr), .wgray(wgray), .wr_fire(wr_fire), .in_ready(in_ready),
    .almost_full_n(almost_full_n), .x_thr(x_thr)
  );

  dcff_sync #(.W(TW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
  );

  dcff_sync #(.W(TW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
  );

  // quasi-static threshold carried into the read domain
  dcff_sync #(.W(TW), .RST_VAL(TW'(AE_DEFAULT))) u_x2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(x_thr), .q(x_thr_s)
  );

  dcff_ram #(.AW(AW), .W(DATA_W)) u_ram (
    .clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  dcff_rd_ctrl #(.AW(AW), .W(DATA_W), .LOOKAHEAD(LOOKAHEAD)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .x_thr_s(x_thr_s), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .rd_avail(rd_avail), .almost_empty_n(almost_empty_n)
  );
endmodule

// File: tb/dual_clock_flag_fifo_tb_top.sv
module dual_clock_flag_fifo_tb_top;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int TW    = $clog2(DEPTH) + 1;
  localparam int XDEF  = 2;
  localparam int YDEF  = 3;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic wr_rst_n = 1'b0;
  logic rd_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [TW-1:0] cfg_wdata = '0;
  logic rd_en_f = 1'b0;
  logic rd_en_s = 1'b0;

  logic in_ready_f, af_f, avail_f, ae_f;
  logic in_ready_s, af_s, avail_s, ae_s;
  logic [DW-1:0] rd_data_f, rd_data_s;

  int n_chk = 0;
  int n_fail = 0;
  int rem_f = 0;
  int rem_s = 0;
  int xv = XDEF;
  int yv = YDEF;

  always #5 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  dual_clock_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LOOKAHEAD(1'b1),
                         .AE_DEFAULT(XDEF), .AF_DEFAULT(YDEF)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .in_ready(in_ready_f), .almost_full_n(af_f), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_clk(rd_clk),
    .rd_rst_n(rd_rst_n), .rd_en(rd_en_f), .rd_data(rd_data_f),
    .rd_avail(avail_f), .almost_empty_n(ae_f)
  );

  dual_clock_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .LOOKAHEAD(1'b0),
                         .AE_DEFAULT(XDEF), .AF_DEFAULT(YDEF)) dut_std_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .in_ready(in_ready_s), .almost_full_n(af_s), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_clk(rd_clk),
    .rd_rst_n(rd_rst_n), .rd_en(rd_en_s), .rd_data(rd_data_s),
    .rd_avail(avail_s), .almost_empty_n(ae_s)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    @(posedge wr_clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge wr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_thr(input logic sel, input int val);
    @(posedge wr_clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = TW'(val);
    @(posedge wr_clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge rd_clk);
    repeat (3) @(posedge wr_clk);
    #1;
  endtask

  // expected flags from the bench's own word counts (R6, R7, R8)
  task automatic check_flags(input string tag);
    int mf, ms;
    mf = (rem_f > 0) ? rem_f - 1 : 0;   // R8: output-register word not counted
    ms = rem_s;
    check("R7", {tag, " in_ready look-ahead"}, in_ready_f, mf < DEPTH);
    check("R7", {tag, " almost_full_n look-ahead"}, af_f, mf < DEPTH - yv);
    check("R8", {tag, " almost_empty_n look-ahead"}, ae_f, mf > xv);
    check("R2", {tag, " rd_avail look-ahead"}, avail_f, rem_f > 0);
    check("R7", {tag, " in_ready request"}, in_ready_s, ms < DEPTH);
    check("R7", {tag, " almost_full_n request"}, af_s, ms < DEPTH - yv);
    check("R6", {tag, " almost_empty_n request"}, ae_s, ms > xv);
    check("R3", {tag, " rd_avail request"}, avail_s, ms > 0);
  endtask

  task automatic sweep(input logic [DW-1:0] base);
    int of_f, of_s;
    of_f = 0; of_s = 0;
    // fill: DEPTH+2 attempts, the extra ones hit a full FIFO (R4)
    for (int i = 0; i < DEPTH + 2; i++) begin
      write_word(base + DW'(i));
      if (rem_f < DEPTH + 1) rem_f++;
      if (rem_s < DEPTH) rem_s++;
      settle();
      check_flags("fill");
      check("R2", "head word in look-ahead output", rd_data_f, base);
    end
    // drain with a read request every step, including past empty
    for (int k = 0; k < DEPTH + 2; k++) begin
      if (rem_f > 0)
        check("R10", "look-ahead order", rd_data_f, base + DW'(of_f));
      @(posedge rd_clk); #1;
      rd_en_f = 1'b1; rd_en_s = 1'b1;
      @(posedge rd_clk); #1;
      rd_en_f = 1'b0; rd_en_s = 1'b0;
      if (rem_s > 0) begin
        check("R10", "request-mode order", rd_data_s, base + DW'(of_s));
        of_s++; rem_s--;
      end else begin
        check("R4", "empty read keeps request data", rd_data_s, base + DW'(DEPTH - 1));
      end
      if (rem_f > 0) begin
        of_f++; rem_f--;
      end
      if (k == 0) begin
        @(posedge wr_clk); #1;
        check("R5", "in_ready low 1 edge after read (look-ahead)", in_ready_f, 1'b0);
        check("R5", "in_ready low 1 edge after read (request)", in_ready_s, 1'b0);
        @(posedge wr_clk); #1;
        check("R5", "in_ready high 2 edges after read (look-ahead)", in_ready_f, 1'b1);
        check("R5", "in_ready high 2 edges after read (request)", in_ready_s, 1'b1);
      end
      settle();
      check_flags("drain");
      if (rem_f == 0)
        check("R4", "empty read keeps look-ahead data", rd_data_f, base + DW'(DEPTH));
    end
    check("R4", "look-ahead accepted exactly DEPTH+1 words", of_f, DEPTH + 1);
    check("R4", "request mode accepted exactly DEPTH words", of_s, DEPTH);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #12;
    // R1: state while reset is held
    check("R1", "in_ready in reset", {in_ready_f, in_ready_s}, 2'b11);
    check("R1", "rd_avail in reset", {avail_f, avail_s}, 2'b00);
    #20;
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (2) @(posedge wr_clk); #1;
    check("R1", "in_ready after reset", {in_ready_f, in_ready_s}, 2'b11);
    check("R1", "almost_full_n after reset", {af_f, af_s}, 2'b11);
    check("R1", "rd_avail after reset", {avail_f, avail_s}, 2'b00);
    check("R1", "almost_empty_n after reset", {ae_f, ae_s}, 2'b00);
    check("R1", "rd_data after reset", {rd_data_f, rd_data_s}, 32'h0);

    // R2/R3: edge-by-edge latency of one word into an empty FIFO
    write_word(16'hBEEF);
    @(posedge rd_clk); #1;
    check("R2", "look-ahead avail after edge 1", avail_f, 1'b0);
    check("R3", "request avail after edge 1", avail_s, 1'b0);
    @(posedge rd_clk); #1;
    check("R2", "look-ahead avail after edge 2", avail_f, 1'b0);
    check("R3", "request avail after edge 2", avail_s, 1'b1);
    rd_en_s = 1'b1;
    @(posedge rd_clk); #1;
    rd_en_s = 1'b0;
    check("R2", "look-ahead avail after edge 3", avail_f, 1'b1);
    check("R2", "look-ahead data after edge 3", rd_data_f, 16'hBEEF);
    check("R3", "request data after read at edge 3", rd_data_s, 16'hBEEF);
    check("R3", "request avail after its read", avail_s, 1'b0);
    rd_en_f = 1'b1;
    @(posedge rd_clk); #1;
    check("R2", "look-ahead avail after consume", avail_f, 1'b0);
    rd_en_s = 1'b1;
    @(posedge rd_clk); #1;
    rd_en_f = 1'b0; rd_en_s = 1'b0;
    check("R4", "look-ahead data after ignored read", rd_data_f, 16'hBEEF);
    check("R4", "request data after ignored read", rd_data_s, 16'hBEEF);
    settle();

    // pass 1: reset-default thresholds (R9); pass 2: programmed, pointers wrap (R10)
    sweep(16'h1100);
    xv = 5; yv = 1;
    set_thr(1'b0, xv);   // R9: cfg_sel=0 writes X
    set_thr(1'b1, yv);   // R9: cfg_sel=1 writes Y
    settle();
    check("R9", "thresholds keep empty flags", {ae_f, ae_s, af_f, af_s}, 4'b0011);
    sweep(16'h2200);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule